// File: doc/BRIEF.md
# Multi-Word Vector Compare and Top-Word Locator

This unit walks big numbers stored as runs of data words in a synchronous single-port RAM. A vector sits at a base word address with its least significant word first. Its length is counted in words. The unit runs one of two jobs for each start pulse.

The compare job reads A and B word pairs from the top word downward and stops at the first pair that differs. It then reports a one-hot three-way result. The locate job reads one vector from the top word downward and stops at the first nonzero word. It reports that word's address in a packed status word, or an all-zero flag when no word is nonzero. On request it also reports the position of the highest set bit inside that word.

The RAM returns data one cycle after the address. Each compare step therefore reads the A word, holds it in a register, and then reads the B word. Result registers change only in the cycle that `done` pulses, so a consumer can read the previous results while a new job is running.

Top module: `vscan_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `cmp_result`, `msw_status` and `top_bit` are all zero.
- R2: A compare treats each vector as one unsigned number whose least significant word is at the base address. `cmp_result` is one-hot:
  - bit 2 means A is greater;
  - bit 1 means A is less;
  - bit 0 means the two are equal.
- R3: A compare reads word pairs from offset len-1 down to offset 0 and stops at the first pair that differs. Each pair costs three clock cycles and two RAM reads. If k pairs were read, `done` is sampled high k*3 rising edges after the edge that accepted `start`.
- R4: `busy` is high from the edge that accepts a nonzero-length start until the edge that raises `done`. `done` is a one-cycle pulse and is never high together with `busy`. `cmp_result`, `msw_status` and `top_bit` change only on the edge that raises `done`.
- R5: A locate reads the vector from offset len-1 downward. At the first nonzero word it writes `msw_status` with bit 15 = 0, bits 14:11 = 0 and bits 10:0 = that word's address (base + offset, modulo 2^AW). Each word read costs two cycles.
- R6: If every word of a located vector is zero, `msw_status` becomes bit 15 = 1 with the base address in bits 10:0, after len reads.
- R7: When `ms_one_en` is set with a locate, `top_bit` receives the index (0 = LSB) of the highest set bit of the word found, or 0 for an all-zero vector. When `ms_one_en` is clear, `top_bit` keeps its value.
- R8: A start with `len` = 0 raises `done` on the next edge with no RAM read and `busy` never high. A compare then reports 3'b001. A locate reports the all-zero status with the base address.
- R9: A `start` pulse while `busy` is high is ignored. The running job's result and timing are unchanged.
- R10: A compare leaves `msw_status` and `top_bit` unchanged. A locate leaves `cmp_result` unchanged.
- R11: `op_sel` = 0 selects compare and `op_sel` = 1 selects locate. The values on `op_sel`, `ms_one_en`, `a_base`, `b_base` and `len` are captured on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| op_sel | input | 1 | 0 = compare, 1 = locate |
| ms_one_en | input | 1 | Request highest-set-bit report with a locate |
| a_base | input | AW (11) | Base word address of vector A (the located vector) |
| b_base | input | AW (11) | Base word address of vector B |
| len | input | LW (9) | Vector length in words |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_addr | output | AW (11) | RAM word address |
| mem_rdata | input | DW (32) | RAM read data, valid one cycle after the strobe |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| cmp_result | output | 3 | One-hot compare result (GT, LT, EQ) |
| msw_status | output | 16 | Zero flag in bit 15, top nonzero word address in low AW bits |
| top_bit | output | log2(DW) (5) | Highest set bit index of the located word |

## Verification
The bench builds the block with its default parameters: 11-bit addresses, 32-bit words and 9-bit lengths. The 32-bit word width lets the bench drive highest-set-bit reports at both ends, index 31 and index 0. The 11-bit address width matches the status field exactly, so every located address can be checked against the full 11-bit status field. The bench's behavioural RAM gives the same one-cycle latency the unit expects, so the per-pair and per-word cycle costs are checked exactly. A seeded pseudo-random series of compares varies the vector length and the position of the differing word.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

  localparam int STAT_W        = 16;
  localparam int ZERO_FLAG_BIT = 15;
  localparam int MAX_ADDR_W    = 15;

  localparam logic [2:0] CMP_GT = 3'b100;
  localparam logic [2:0] CMP_LT = 3'b010;
  localparam logic [2:0] CMP_EQ = 3'b001;

  localparam logic OP_CMP = 1'b0;
  localparam logic OP_LOC = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CMP,
    ST_LOC
  } vscan_state_e;

  // Packs the zero flag and a word address into the status layout.
  function automatic logic [STAT_W-1:0] msw_pack(input logic zero,
                                                 input logic [MAX_ADDR_W-1:0] addr);
    logic [STAT_W-1:0] s;
    s = '0;
    s[ZERO_FLAG_BIT] = zero;
    s[MAX_ADDR_W-1:0] = addr;
    return s;
  endfunction

  // Three-way result code from the word relation flags.
  function automatic logic [2:0] cmp_code(input logic gt, input logic lt);
    if (gt) return CMP_GT;
    if (lt) return CMP_LT;
    return CMP_EQ;
  endfunction

endpackage

// File: rtl/vscan_word_cmp.sv
module vscan_word_cmp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_a,
  input  logic [DW-1:0] word_b,
  output logic          a_gt,
  output logic          a_lt
);

  assign a_gt = word_a > word_b;
  assign a_lt = word_a < word_b;

endmodule

// File: rtl/vscan_msb_enc.sv
module vscan_msb_enc #(
  parameter int DW = 32,
  localparam int BW = $clog2(DW)
) (
  input  logic [DW-1:0] word,
  output logic          nz,
  output logic [BW-1:0] idx
);

  // Highest set bit position; lower bits are overridden by higher ones.
  function automatic logic [BW-1:0] top_index(input logic [DW-1:0] w);
    logic [BW-1:0] r;
    r = '0;
    for (int i = 0; i < DW; i++) begin
      if (w[i]) r = BW'(i);
    end
    return r;
  endfunction

  assign nz  = |word;
  assign idx = top_index(word);

  always_comb begin
    if (nz) begin
      p_msb_is_top_r7: assert (word[idx] && ((word >> idx) == DW'(1)));
    end
  end

endmodule

// File: rtl/vscan_ctrl.sv
module vscan_ctrl
  import vscan_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 32,
  parameter int LW = 9,
  localparam int BW = $clog2(DW),
  localparam int XW = AW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sel,
  input  logic          ms_one_en,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  input  logic [LW-1:0] len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] a_word,
  input  logic          wd_gt,
  input  logic          wd_lt,
  input  logic          enc_nz,
  input  logic [BW-1:0] enc_idx,
  output logic          busy,
  output logic          done,
  output logic [2:0]    cmp_result,
  output logic [STAT_W-1:0] msw_status,
  output logic [BW-1:0] top_bit
);

  vscan_state_e st_q;
  logic [LW-1:0] idx_q, len_q;
  logic [AW-1:0] a_base_q, b_base_q;
  logic          op_q, ms_q, busy_q, done_q;
  logic [DW-1:0] a_word_q;
  logic [2:0]    cmp_q;
  logic [STAT_W-1:0] msw_q;
  logic [BW-1:0] bit_q;

  // Named internal events
  logic          start_take, len_zero_take, last_word, pair_differs;
  logic          cmp_finish, loc_finish, finish;
  logic [AW-1:0] a_addr, b_addr;

  assign start_take    = start && (st_q == ST_IDLE);
  assign len_zero_take = start_take && (len == '0);
  assign last_word     = (idx_q == '0);
  assign pair_differs  = wd_gt || wd_lt;
  assign cmp_finish    = (st_q == ST_CMP) && (pair_differs || last_word);
  assign loc_finish    = (st_q == ST_LOC) && (enc_nz || last_word);
  assign finish        = cmp_finish || loc_finish || len_zero_take;

  assign a_addr    = a_base_q + AW'(idx_q);
  assign b_addr    = b_base_q + AW'(idx_q);
  assign mem_rd_en = (st_q == ST_RD_A) || (st_q == ST_RD_B);
  assign mem_addr  = (st_q == ST_RD_B) ? b_addr : a_addr;

  // Sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      a_base_q <= '0;
      b_base_q <= '0;
      op_q     <= OP_CMP;
      ms_q     <= 1'b0;
      a_word_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (st_q)
        ST_IDLE: begin
          if (start_take) begin
            a_base_q <= a_base;
            b_base_q <= b_base;
            len_q    <= len;
            op_q     <= op_sel;
            ms_q     <= ms_one_en;
            idx_q    <= len - LW'(1);
            if (len != '0) begin
              busy_q <= 1'b1;
              st_q   <= ST_RD_A;
            end
          end
        end
        ST_RD_A: st_q <= (op_q == OP_LOC) ? ST_LOC : ST_RD_B;
        ST_RD_B: begin
          a_word_q <= mem_rdata;
          st_q     <= ST_CMP;
        end
        ST_CMP, ST_LOC: begin
          if (finish) begin
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q - LW'(1);
            st_q  <= ST_RD_A;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Result registers, written only on completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      msw_q <= '0;
      bit_q <= '0;
    end else begin
      if (len_zero_take) begin
        if (op_sel == OP_CMP) begin
          cmp_q <= CMP_EQ;
        end else begin
          msw_q <= msw_pack(1'b1, MAX_ADDR_W'(a_base));
          if (ms_one_en) bit_q <= '0;
        end
      end
      if (cmp_finish) cmp_q <= cmp_code(wd_gt, wd_lt);
      if (loc_finish) begin
        msw_q <= enc_nz ? msw_pack(1'b0, MAX_ADDR_W'(a_addr))
                        : msw_pack(1'b1, MAX_ADDR_W'(a_base_q));
        if (ms_q) bit_q <= enc_nz ? enc_idx : '0;
      end
    end
  end

  assign a_word     = a_word_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign cmp_result = cmp_q;
  assign msw_status = msw_q;
  assign top_bit    = bit_q;

  // Reads stay inside one of the two vectors being walked
  p_rd_in_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((XW'(AW'(mem_addr - a_base_q)) < XW'(len_q)) ||
                   (XW'(AW'(mem_addr - b_base_q)) < XW'(len_q))));

  p_onehot_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_q));

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_cmp_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> done_q);

  p_msw_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msw_q) |-> done_q);

  p_bit_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_q) |-> done_q);

  p_no_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy_q);

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/vscan_unit.sv
module vscan_unit
  import vscan_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 32,
  parameter int LW = 9,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sel,
  input  logic          ms_one_en,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  input  logic [LW-1:0] len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    cmp_result,
  output logic [STAT_W-1:0] msw_status,
  output logic [BW-1:0] top_bit
);

  logic [DW-1:0] a_word;
  logic          wd_gt, wd_lt, enc_nz;
  logic [BW-1:0] enc_idx;

  vscan_word_cmp #(.DW(DW)) i_cmp (
    .word_a (a_word),
    .word_b (mem_rdata),
    .a_gt   (wd_gt),
    .a_lt   (wd_lt)
  );

  vscan_msb_enc #(.DW(DW)) i_enc (
    .word (mem_rdata),
    .nz   (enc_nz),
    .idx  (enc_idx)
  );

  vscan_ctrl #(.AW(AW), .DW(DW), .LW(LW)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_sel     (op_sel),
    .ms_one_en  (ms_one_en),
    .a_base     (a_base),
    .b_base     (b_base),
    .len        (len),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .a_word     (a_word),
    .wd_gt      (wd_gt),
    .wd_lt      (wd_lt),
    .enc_nz     (enc_nz),
    .enc_idx    (enc_idx),
    .busy       (busy),
    .done       (done),
    .cmp_result (cmp_result),
    .msw_status (msw_status),
    .top_bit    (top_bit)
  );

endmodule

// File: tb/test_vscan_unit.sv
module test_vscan_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_sel = 1'b0;
  logic        ms_one_en = 1'b0;
  logic [10:0] a_base = '0;
  logic [10:0] b_base = '0;
  logic [8:0]  len = '0;
  logic        mem_rd_en;
  logic [10:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;
  logic [2:0]  cmp_result;
  logic [15:0] msw_status;
  logic [4:0]  top_bit;

  logic [31:0] mem [0:2047];
  int          rd_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  vscan_unit i_vscan_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .ms_one_en(ms_one_en), .a_base(a_base), .b_base(b_base), .len(len),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cmp_result(cmp_result),
    .msw_status(msw_status), .top_bit(top_bit)
  );

  // Behavioural RAM, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Reference compare: scan top down, count pairs read
  function automatic logic [2:0] ref_cmp(input int ab, input int bb, input int ln,
                                         output int k);
    k = 0;
    for (int i = ln - 1; i >= 0; i--) begin
      k++;
      if (mem[(ab + i) % 2048] > mem[(bb + i) % 2048]) return 3'b100;
      if (mem[(ab + i) % 2048] < mem[(bb + i) % 2048]) return 3'b010;
    end
    return 3'b001;
  endfunction

  // Reference locate: status word, bit index, words read
  function automatic logic [15:0] ref_loc(input int ab, input int ln,
                                          output int bitpos, output int j);
    j = 0;
    bitpos = 0;
    for (int i = ln - 1; i >= 0; i--) begin
      j++;
      if (mem[(ab + i) % 2048] != 0) begin
        for (int b = 31; b >= 0; b--)
          if (mem[(ab + i) % 2048][b]) begin bitpos = b; break; end
        return 16'((ab + i) % 2048);
      end
    end
    return 16'h8000 | 16'(ab);
  endfunction

  // One job: start, wait for done, check timing, stability and outputs
  task automatic run_job(input logic op, input logic ms, input int ab, input int bb,
                         input int ln, input string tag);
    logic [2:0]  c0, ec;
    logic [15:0] m0, em;
    logic [4:0]  t0, et;
    int k, bp, cyc, rd0, exp_cyc, exp_rd;
    bit stable_ok, busy_ok;
    c0 = cmp_result; m0 = msw_status; t0 = top_bit;
    if (op == 1'b0) begin
      ec = ref_cmp(ab, bb, ln, k); exp_cyc = 3 * k + 1; exp_rd = 2 * k;
      em = m0; et = t0;
    end else begin
      em = ref_loc(ab, ln, bp, k); exp_cyc = 2 * k + 1; exp_rd = k;
      ec = c0; et = ms ? 5'(bp) : t0;
    end
    @(negedge clk);
    start = 1'b1; op_sel = op; ms_one_en = ms;
    a_base = 11'(ab); b_base = 11'(bb); len = 9'(ln);
    rd0 = rd_cnt;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; stable_ok = 1; busy_ok = 1;
    while (!done && cyc < 2000) begin
      if (cmp_result != c0 || msw_status != m0 || top_bit != t0) stable_ok = 0;
      if (!busy) busy_ok = 0;
      @(negedge clk);
      cyc++;
    end
    // R3, R6 and R8: cycles counted from the accepting edge plus one
    chk(cyc == exp_cyc, (op == 1'b0) ? "R3" : "R6", {tag, " latency"}, cyc, exp_cyc);
    chk(rd_cnt - rd0 == exp_rd, "R3", {tag, " reads"}, rd_cnt - rd0, exp_rd);
    chk(stable_ok && busy_ok, "R4", {tag, " busy/stable before done"},
        {stable_ok, busy_ok}, 2'b11);
    chk(!busy, "R4", {tag, " busy low at done"}, busy, 0);
    chk(cmp_result == ec, "R2", {tag, " cmp_result"}, cmp_result, ec);
    chk(msw_status == em, "R5", {tag, " msw_status"}, msw_status, em);
    chk(top_bit == et, "R7", {tag, " top_bit"}, top_bit, et);
    @(negedge clk);
    chk(!done, "R4", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(cmp_result == 0 && msw_status == 0 && top_bit == 0, "R1",
        "results after reset", {cmp_result, msw_status, top_bit}, 0);
  endtask

  task automatic t_cmp_basic();
    for (int i = 0; i < 4; i++) begin mem[100 + i] = 32'h1000 * i + 7; mem[200 + i] = 32'h1000 * i + 7; end
    run_job(1'b0, 1'b0, 100, 200, 4, "R2 equal");
    mem[203] = 32'h0000_3005;
    run_job(1'b0, 1'b0, 100, 200, 4, "R3 top differs GT");
    // R2: least significant word at base; top word decides over lower words
    mem[300] = 32'h0; mem[301] = 32'h2;
    mem[400] = 32'hFFFF_FFFF; mem[401] = 32'h1;
    run_job(1'b0, 1'b0, 300, 400, 2, "R2 word order");
    for (int i = 0; i < 5; i++) begin mem[500 + i] = 32'hA5; mem[600 + i] = 32'hA5; end
    mem[500] = 32'hA4;
    run_job(1'b0, 1'b0, 500, 600, 5, "R3 bottom differs LT");
  endtask

  task automatic t_locate();
    for (int i = 0; i < 6; i++) mem[700 + i] = 0;
    mem[702] = 32'h0008_0000; mem[700] = 32'hFFFF;
    run_job(1'b1, 1'b1, 700, 0, 6, "R5 mid word bit 19");
    mem[2040] = 32'h8000_0000;
    run_job(1'b1, 1'b1, 2040, 0, 8, "R7 bit 31 top of space");
    mem[710] = 32'h1;
    run_job(1'b1, 1'b1, 710, 0, 1, "R7 bit 0");
    mem[720] = 32'h0400_0000;
    run_job(1'b1, 1'b0, 720, 0, 1, "R7 ms_one off keeps top_bit");
    for (int i = 0; i < 3; i++) mem[730 + i] = 0;
    run_job(1'b1, 1'b1, 730, 0, 3, "R6 all zero");
    // R10: compare after locate leaves msw_status/top_bit (checked in run_job)
    run_job(1'b0, 1'b0, 100, 200, 4, "R10 cmp keeps msw");
  endtask

  task automatic t_len_zero();
    run_job(1'b0, 1'b0, 12, 34, 0, "R8 len0 compare");
    run_job(1'b1, 1'b1, 55, 0, 0, "R8 len0 locate");
  endtask

  task automatic t_start_busy();
    logic [15:0] m0;
    int cyc;
    for (int i = 0; i < 8; i++) begin mem[800 + i] = 32'h55 + i; mem[900 + i] = 32'h55 + i; end
    m0 = msw_status;
    @(negedge clk);
    start = 1'b1; op_sel = 1'b0; ms_one_en = 1'b0; a_base = 800; b_base = 900; len = 8;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    repeat (5) begin @(negedge clk); cyc++; end
    start = 1'b1; op_sel = 1'b1; ms_one_en = 1'b1; a_base = 7; len = 0;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(cyc == 25, "R9", "latency with start while busy", cyc, 25);
    chk(cmp_result == 3'b001, "R9", "cmp_result", cmp_result, 3'b001);
    chk(msw_status == m0, "R9", "msw_status untouched", msw_status, m0);
  endtask

  task automatic t_random_cmp();
    for (int n = 0; n < 16; n++) begin
      int ln, p;
      ln = 1 + int'(rnd() % 8);
      for (int i = 0; i < ln; i++) begin mem[1000 + i] = rnd(); mem[1100 + i] = mem[1000 + i]; end
      p = int'(rnd() % 32'(ln));
      if (n % 4 != 3) mem[1100 + p] = mem[1100 + p] ^ (32'h1 << (rnd() % 32));
      run_job(1'b0, 1'b0, 1000, 1100, ln, "R11 random compare");
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    t_reset();
    t_cmp_basic();
    t_locate();
    t_len_zero();
    t_start_busy();
    t_random_cmp();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule